// File: doc/BRIEF.md
# Playback Channel Mute, Gain and Headphone Routing

This block sits on the digital playback path of an eight-speaker output stage that also has a stereo headphone output. Each frame carries one signed 16-bit sample for every speaker channel, marked by a one-cycle valid strobe. For each channel the block scales the sample by a 6-bit linear attenuation code. It then applies a per-output mute mask, picks which channel pair feeds the headphone, and converts every result to the unsigned, offset-shifted code that the converters downstream take.

A 16-bit control word sets the muting and the headphone routing. A write to the control word is held in a register and is picked up only when the next frame strobe arrives, so a single frame never uses a mix of old and new settings. There is a safety override for the case where a headphone is detected while the host driver flag is clear: every speaker output is silenced, the headphone is fed from the front pair, and the headphone mute bits are ignored.

Top module: `playback_router`

## Requirements
- R1: After reset, out_valid is 0, every speaker and headphone output holds the digital-zero code 32832, and the control word reads as 0x0004 (driver flag 0, headphone source front, no channel muted).
- R2: Every output sample is the signed result v converted to 17 bits unsigned: the sign bit of v is inverted, giving a 16-bit value, and 64 is added. So -32768 gives 64, -1 gives 32831, 0 gives 32832 and 32767 gives 65599.
- R3: Gain code c in 0..36 multiplies the sample s by the coefficient k = 32768 - 908*c. The result is floor(s*k/32768), so code 0 passes the sample through unchanged. Any code of 37 or more gives 0.
- R4: Speaker channel order is left front, right front, center, subwoofer, left surround, right surround, side left, side right (lanes 0..7 of in_samples, in_gain and out_spk). Control bits 12:3 are the mute mask, with bit 3+i muting speaker lane i and bits 11 and 12 muting headphone left and right. A muted output carries 32832.
- R5: Control bits 14:13 pick the headphone source pair: 00 front (lanes 0,1), 01 center and subwoofer (2,3), 10 surround (4,5), 11 side (6,7). The headphone uses the gain-scaled samples of that pair, and speaker mute bits do not affect it.
- R6: When hp_detect is 1 and control bit 15 (driver flag) is 0, all eight speaker outputs carry 32832 and the headphone carries the scaled front pair. In this case the mask and the headphone select bits are ignored.
- R7: When hp_detect is 1 and the driver flag is 1, the mask and the headphone select apply exactly as in R4 and R5.
- R8: The control word and hp_detect in force for a frame are the values held when in_valid is sampled. A write issued in the same cycle as in_valid takes effect from the following frame.
- R9: out_valid pulses for one cycle two clock edges after the in_valid edge. Outputs hold their values between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write enable |
| ctrl_wdata | input | 16 | Control word write data |
| hp_detect | input | 1 | Headphone plugged indication |
| in_valid | input | 1 | Frame strobe |
| in_samples | input | 128 | Eight signed 16-bit samples, lane i at bits 16i+15:16i |
| in_gain | input | 48 | Eight 6-bit gain codes, lane i at bits 6i+5:6i |
| out_valid | output | 1 | Output frame strobe |
| out_spk | output | 136 | Eight unsigned 17-bit speaker codes |
| out_hp | output | 34 | Headphone left (low) and right (high), 17 bits each |

## Verification
The override and the normal mask/select logic can fall in the same frame. To provoke this, a control word is loaded with speaker and headphone mute bits set and the side pair selected, and a frame is then sent with hp_detect high. A correct result has silent speakers and an unmuted headphone that carries the front pair, and setting the driver flag in the next frame must bring back the masked routing. A second collision comes from issuing a control write in the same cycle as a frame strobe. That frame is judged against the old settings and the one after it against the new settings.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  parameter int PB_CHANNELS   = 8;
  parameter int PB_SAMPLE_W   = 16;
  parameter int PB_GAIN_W     = 6;
  parameter int PB_CTRL_W     = 16;
  parameter int PB_OFFSET     = 64;
  parameter int PB_MUTE_CODE  = 37;
  parameter int PB_GAIN_STEP  = 908;
  parameter logic [15:0] PB_CTRL_RESET = 16'h0004;
  // control word field positions
  parameter int PB_DRV_BIT    = 15;
  parameter int PB_SEL_LO     = 13;
  parameter int PB_MASK_LO    = 3;
endpackage

// File: rtl/pbr_ctrl.sv
module pbr_ctrl
  import pbr_pkg::*;
#(
  parameter int NCH    = PB_CHANNELS,
  parameter int CTRL_W = PB_CTRL_W,
  localparam int SEL_W = $clog2(NCH / 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              hp_detect,
  input  logic              in_valid,
  output logic              a_valid,
  output logic              a_override,
  output logic [NCH-1:0]    a_spk_mute,
  output logic [1:0]        a_hp_mute,
  output logic [SEL_W-1:0]  a_sel
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              ovr;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= PB_CTRL_RESET;
    else if (ctrl_we) ctrl_q <= ctrl_wdata;
  end

  assign ovr = hp_detect & ~ctrl_q[PB_DRV_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      a_valid    <= 1'b0;
      a_override <= 1'b0;
      a_spk_mute <= '0;
      a_hp_mute  <= '0;
      a_sel      <= '0;
    end else begin
      a_valid <= in_valid;
      if (in_valid) begin
        a_override <= ovr;
        a_spk_mute <= ovr ? '1 : ctrl_q[PB_MASK_LO +: NCH];
        a_hp_mute  <= ovr ? 2'b00 : ctrl_q[PB_MASK_LO + NCH +: 2];
        a_sel      <= ovr ? '0 : ctrl_q[PB_SEL_LO +: SEL_W];
      end
    end
  end

  // R8: control word only moves on a write
  assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !ctrl_we |=> $stable(ctrl_q));
  // R6: override routing never keeps headphone muted or a non-front source
  assert_override_route_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hp_detect && !ctrl_q[PB_DRV_BIT]) |=> (a_hp_mute == 2'b00 && a_sel == '0));
endmodule

// File: rtl/pbr_gain_lane.sv
module pbr_gain_lane
  import pbr_pkg::*;
#(
  parameter int SW        = PB_SAMPLE_W,
  parameter int GW        = PB_GAIN_W,
  parameter int MUTE_CODE = PB_MUTE_CODE,
  parameter int STEP      = PB_GAIN_STEP,
  localparam int KW       = SW + 2,
  localparam int PW       = SW + KW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [SW-1:0] sample,
  input  logic [GW-1:0] code,
  output logic [SW-1:0] scaled
);
  localparam int UNITY = 1 << (SW - 1);

  logic signed [KW-1:0] coef;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shifted;

  always_comb begin
    if (int'(code) >= MUTE_CODE) coef = '0;
    else coef = KW'(UNITY - STEP * int'(code));
  end

  assign prod    = $signed(sample) * coef;
  assign shifted = prod >>> (SW - 1);

  always_ff @(posedge clk) begin
    if (rst) scaled <= '0;
    else if (load) scaled <= shifted[SW-1:0];
  end

  // R3: scaled product always fits the sample width
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    load |-> (shifted[PW-1:SW-1] == '0 || shifted[PW-1:SW-1] == '1));
  // R3: unity code passes the sample through
  assert_unity_gain_R3: assert property (@(posedge clk) disable iff (rst)
    (load && code == '0) |=> scaled == $past(sample));
endmodule

// File: rtl/pbr_out_stage.sv
module pbr_out_stage
  import pbr_pkg::*;
#(
  parameter int NCH    = PB_CHANNELS,
  parameter int SW     = PB_SAMPLE_W,
  parameter int OFFSET = PB_OFFSET,
  localparam int OW    = SW + 1,
  localparam int SEL_W = $clog2(NCH / 2),
  localparam logic [OW-1:0] ZERO_CODE = OW'((1 << (SW - 1)) + OFFSET)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_valid,
  input  logic [NCH*SW-1:0] scaled,
  input  logic [NCH-1:0]    a_spk_mute,
  input  logic [1:0]        a_hp_mute,
  input  logic [SEL_W-1:0]  a_sel,
  output logic              out_valid,
  output logic [NCH*OW-1:0] out_spk,
  output logic [2*OW-1:0]   out_hp
);
  function automatic logic [OW-1:0] to_offset(input logic [SW-1:0] v);
    return OW'({~v[SW-1], v[SW-2:0]}) + OW'(OFFSET);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else out_valid <= a_valid;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_spk
    always_ff @(posedge clk) begin
      if (rst) out_spk[i*OW +: OW] <= ZERO_CODE;
      else if (a_valid)
        out_spk[i*OW +: OW] <= a_spk_mute[i] ? ZERO_CODE : to_offset(scaled[i*SW +: SW]);
    end
    // R4: a muted lane carries digital zero
    assert_lane_mute_R4: assert property (@(posedge clk) disable iff (rst)
      (a_valid && a_spk_mute[i]) |=> out_spk[i*OW +: OW] == ZERO_CODE);
    // R2: codes stay in the converted range
    assert_code_range_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_spk[i*OW +: OW] >= OW'(OFFSET) &&
                     out_spk[i*OW +: OW] <= OW'((1 << SW) - 1 + OFFSET)));
  end

  for (genvar j = 0; j < 2; j++) begin : g_hp
    always_ff @(posedge clk) begin
      if (rst) out_hp[j*OW +: OW] <= ZERO_CODE;
      else if (a_valid)
        out_hp[j*OW +: OW] <= a_hp_mute[j] ? ZERO_CODE
                              : to_offset(scaled[(2 * int'(a_sel) + j) * SW +: SW]);
    end
  end

  // R9: outputs hold between frames
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !a_valid |=> ($stable(out_spk) && $stable(out_hp)));
endmodule

// File: rtl/playback_router.sv
module playback_router
  import pbr_pkg::*;
#(
  parameter int NCH    = PB_CHANNELS,
  parameter int SW     = PB_SAMPLE_W,
  parameter int GW     = PB_GAIN_W,
  parameter int CTRL_W = PB_CTRL_W,
  localparam int OW    = SW + 1,
  localparam int SEL_W = $clog2(NCH / 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              hp_detect,
  input  logic              in_valid,
  input  logic [NCH*SW-1:0] in_samples,
  input  logic [NCH*GW-1:0] in_gain,
  output logic              out_valid,
  output logic [NCH*OW-1:0] out_spk,
  output logic [2*OW-1:0]   out_hp
);
  logic              a_valid;
  logic              a_override;
  logic [NCH-1:0]    a_spk_mute;
  logic [1:0]        a_hp_mute;
  logic [SEL_W-1:0]  a_sel;
  logic [NCH*SW-1:0] scaled;

  pbr_ctrl #(.NCH(NCH), .CTRL_W(CTRL_W)) ctrl_i (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .hp_detect(hp_detect), .in_valid(in_valid), .a_valid(a_valid),
    .a_override(a_override), .a_spk_mute(a_spk_mute), .a_hp_mute(a_hp_mute),
    .a_sel(a_sel)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    pbr_gain_lane #(.SW(SW), .GW(GW)) lane_i (
      .clk(clk), .rst(rst), .load(in_valid),
      .sample(in_samples[i*SW +: SW]), .code(in_gain[i*GW +: GW]),
      .scaled(scaled[i*SW +: SW])
    );
  end

  pbr_out_stage #(.NCH(NCH), .SW(SW)) out_i (
    .clk(clk), .rst(rst), .a_valid(a_valid), .scaled(scaled),
    .a_spk_mute(a_spk_mute), .a_hp_mute(a_hp_mute), .a_sel(a_sel),
    .out_valid(out_valid), .out_spk(out_spk), .out_hp(out_hp)
  );

  // R6: override frame silences every speaker
  assert_override_silence_R6: assert property (@(posedge clk) disable iff (rst)
    (a_valid && a_override) |=> (out_spk == {NCH{OW'((1 << (SW - 1)) + PB_OFFSET)}}));
  // R9: output strobe follows the staged strobe
  assert_valid_follow_R9: assert property (@(posedge clk) disable iff (rst)
    a_valid |=> out_valid);
endmodule

// File: tb/playback_router_tb.sv
module playback_router_tb_top;
  localparam int NCH = 8, SW = 16, GW = 6, OW = 17;
  localparam int ZC = 32832;

  logic clk = 0, rst = 1, ctrl_we = 0, hp_detect = 0, in_valid = 0;
  logic [15:0] ctrl_wdata = '0;
  logic [NCH*SW-1:0] in_samples = '0;
  logic [NCH*GW-1:0] in_gain = '0;
  logic out_valid;
  logic [NCH*OW-1:0] out_spk;
  logic [2*OW-1:0] out_hp;

  int n_chk = 0, n_bad = 0;
  logic signed [15:0] smp [NCH];
  int gcode [NCH];

  always #2.5 clk = ~clk;

  playback_router dut_i (.*);

  initial begin
    #1_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: run did not finish, act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  function automatic int conv(input int v);
    logic [15:0] b = 16'(v);
    return int'({~b[15], b[14:0]}) + 64;
  endfunction

  function automatic int gain(input int s, input int c);
    longint p;
    if (c >= 37) return 0;
    p = longint'(s) * longint'(32768 - 908 * c);
    return int'(p >>> 15);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [15:0] w);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = w;
    @(negedge clk); ctrl_we = 0;
  endtask

  // present frame, then sample after two edges
  task automatic frame();
    @(negedge clk);
    for (int i = 0; i < NCH; i++) begin
      in_samples[i*SW +: SW] = smp[i];
      in_gain[i*GW +: GW] = 6'(gcode[i]);
    end
    in_valid = 1;
    @(negedge clk); in_valid = 0;
    @(negedge clk);
  endtask

  function automatic int spk(input int i); return int'(out_spk[i*OW +: OW]); endfunction
  function automatic int hp(input int j); return int'(out_hp[j*OW +: OW]); endfunction

  task automatic set_ramp();
    for (int i = 0; i < NCH; i++) begin smp[i] = 16'(1000 * (i + 1) - 3500); gcode[i] = 0; end
  endtask

  task automatic t_reset();
    chk(out_valid == 0, "R1 valid", out_valid, 0);
    chk(spk(0) == ZC && spk(7) == ZC, "R1 spk zero", spk(0), ZC);
    chk(hp(0) == ZC && hp(1) == ZC, "R1 hp zero", hp(1), ZC);
    // reset control 0x0004: driver flag clear, so detect triggers override
    set_ramp(); hp_detect = 1; frame();
    chk(spk(0) == ZC, "R1 reset ctrl override", spk(0), ZC);
    hp_detect = 0; frame();
    chk(spk(3) == conv(smp[3]) && hp(1) == conv(smp[1]), "R1 reset ctrl routing", hp(1), conv(smp[1]));
  endtask

  task automatic t_convert();
    smp[0] = -16'sd32768; smp[1] = -16'sd1; smp[2] = 16'sd0; smp[3] = 16'sd32767;
    for (int i = 4; i < NCH; i++) smp[i] = 16'(i * 77);
    for (int i = 0; i < NCH; i++) gcode[i] = 0;
    wr_ctrl(16'h8000);
    @(negedge clk);
    for (int i = 0; i < NCH; i++) in_samples[i*SW +: SW] = smp[i];
    in_gain = '0; in_valid = 1;
    @(negedge clk); in_valid = 0;
    chk(out_valid == 0, "R9 not yet valid", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1, "R9 valid pulse", out_valid, 1);
    chk(spk(0) == 64, "R2 min", spk(0), 64);
    chk(spk(1) == 32831, "R2 minus one", spk(1), 32831);
    chk(spk(2) == ZC, "R2 zero", spk(2), ZC);
    chk(spk(3) == 65599, "R2 max", spk(3), 65599);
    @(negedge clk);
    chk(out_valid == 0 && spk(3) == 65599, "R9 hold", spk(3), 65599);
  endtask

  task automatic t_gain();
    int codes [NCH] = '{0, 5, 20, 36, 37, 50, 63, 1};
    for (int i = 0; i < NCH; i++) begin smp[i] = (i % 2) ? -16'sd12345 : 16'sd10000; gcode[i] = codes[i]; end
    frame();
    for (int i = 0; i < NCH; i++) begin
      int e = conv(gain(int'(smp[i]), gcode[i]));
      chk(spk(i) == e, $sformatf("R3 code %0d", gcode[i]), spk(i), e);
    end
  endtask

  task automatic t_mask();
    set_ramp();
    // driver on, mute lanes 2 and 5 and headphone right: bits 5, 8, 12
    wr_ctrl(16'h8000 | 16'h0020 | 16'h0100 | 16'h1000);
    frame();
    for (int i = 0; i < NCH; i++) begin
      int e = (i == 2 || i == 5) ? ZC : conv(smp[i]);
      chk(spk(i) == e, "R4 mask lane", spk(i), e);
    end
    chk(hp(0) == conv(smp[0]) && hp(1) == ZC, "R4 hp right mute", hp(1), ZC);
  endtask

  task automatic t_select();
    set_ramp(); gcode[5] = 10;
    for (int s = 0; s < 4; s++) begin
      // speakers all masked: headphone unaffected (R5)
      wr_ctrl(16'h8000 | 16'(s << 13) | 16'h07F8);
      frame();
      chk(hp(0) == conv(gain(int'(smp[2*s]), gcode[2*s])), $sformatf("R5 sel %0d left", s), hp(0), conv(gain(int'(smp[2*s]), gcode[2*s])));
      chk(hp(1) == conv(gain(int'(smp[2*s+1]), gcode[2*s+1])), $sformatf("R5 sel %0d right", s), hp(1), conv(gain(int'(smp[2*s+1]), gcode[2*s+1])));
    end
    chk(spk(0) == ZC, "R4 all masked", spk(0), ZC);
  endtask

  task automatic t_override();
    set_ramp(); gcode[0] = 3;
    wr_ctrl(16'h6000 | 16'h1FF8);  // side pair, everything muted, driver off
    hp_detect = 1; frame();
    for (int i = 0; i < NCH; i++) chk(spk(i) == ZC, "R6 speaker silenced", spk(i), ZC);
    chk(hp(0) == conv(gain(int'(smp[0]), 3)), "R6 hp front left", hp(0), conv(gain(int'(smp[0]), 3)));
    chk(hp(1) == conv(smp[1]), "R6 hp front right", hp(1), conv(smp[1]));
    wr_ctrl(16'hE000 | 16'h0018);  // driver on, side, mute lanes 0,1
    frame();
    chk(spk(0) == ZC && spk(2) == conv(smp[2]), "R7 mask applies", spk(2), conv(smp[2]));
    chk(hp(0) == conv(smp[6]) && hp(1) == conv(smp[7]), "R7 select applies", hp(1), conv(smp[7]));
    hp_detect = 0;
  endtask

  task automatic t_boundary();
    set_ramp();
    wr_ctrl(16'h8000);
    @(negedge clk);
    for (int i = 0; i < NCH; i++) begin in_samples[i*SW +: SW] = smp[i]; in_gain[i*GW +: GW] = '0; end
    in_valid = 1; ctrl_we = 1; ctrl_wdata = 16'h8000 | 16'h07F8;
    @(negedge clk); in_valid = 0; ctrl_we = 0;
    @(negedge clk);
    chk(spk(4) == conv(smp[4]), "R8 same-cycle write deferred", spk(4), conv(smp[4]));
    frame();
    chk(spk(4) == ZC, "R8 write applied next frame", spk(4), ZC);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_convert();
    t_gain();
    t_mask();
    t_select();
    t_override();
    t_boundary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule